// File: doc/BRIEF.md
# Block Move Sequencer

This block carries out one two-word block move instruction. The first word holds a 24-bit byte count and two mode bits. The second word holds an address operand. The block first works out where the data lives and how many bytes to move. In direct mode the operand is the data address. In indirect mode the operand points to a memory word that holds the data address. In table mode the operand is an offset from a table base register, and the table entry there supplies both the count and the address.

After that, the block issues data beats on a transfer port. Each beat names the current address and the largest byte count the beat may carry. The far side answers with the number of bytes it actually moved. The block keeps a remaining-count register and a next-address register. Each accepted beat lowers the first and raises the second by the bytes moved. When nothing remains, the block pulses a request for the next instruction. An instruction with both mode bits set is rejected with an error pulse.

The instruction input and the transfer port are valid/ready. A source may hold `instr_valid` for as long as it likes, and the word is taken only in a cycle where `instr_ready` is also high. The block keeps `xfer_valid`, `xfer_addr` and `xfer_max` steady until `xfer_ready` is seen, so the transfer side can stall for any number of cycles. The pointer and table reads use a request/acknowledge port. Its address is held until the acknowledge arrives, and the data is taken in the acknowledge cycle.

Top module: `blkmove_seq`

## Requirements
- R1: After reset `instr_ready` is 1 and `rd_req`, `xfer_valid`, `next_req` and `illegal_err` are 0. `instr_ready` is 1 only while idle, and it drops in the cycle after an instruction is accepted.
- R2: With instruction bits 29 and 28 both 0 (direct), the byte count is `instr_w0[23:0]` and the first beat's `xfer_addr` is `instr_w1`. No memory read is made.
- R3: On each beat where `xfer_valid` and `xfer_ready` are high, the remaining count falls by `xfer_bytes` and the next `xfer_addr` is the previous one plus `xfer_bytes`, modulo 2^32. The beats carry exactly the resolved byte count in total.
- R4: While `xfer_valid` is high, `xfer_max` equals the smaller of the remaining count and 4. It is therefore never 0.
- R5: In the cycle after the beat that empties the count, `next_req` is high for exactly one cycle. In the following cycle `instr_ready` is 1 again.
- R6: With bit 29 set and bit 28 clear (indirect) and a nonzero count, exactly one read is made at `instr_w1`. The returned `rd_data` becomes the data address, and the count is `instr_w0[23:0]`.
- R7: With bit 28 set and bit 29 clear (table), the first read is at `tbl_base + instr_w1`, and bits 23:0 of its data give the count. The second read is at that address plus 4, and its data gives the data address. `instr_w0[23:0]` has no effect.
- R8: With bits 29 and 28 both set, `illegal_err` pulses for one cycle in the cycle after acceptance. No read, no beat and no `next_req` follow.
- R9: A resolved count of zero gives the `next_req` pulse without any beat. In indirect mode no pointer read is made. In table mode only the first table read is made.
- R10: While `rd_req` is high and `rd_ack` is low, `rd_req` stays high and `rd_addr` stays unchanged in the next cycle.
- R11: While `xfer_valid` is high and `xfer_ready` is low, `xfer_valid`, `xfer_addr` and `xfer_max` hold in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction words offered |
| instr_ready | output | 1 | Block idle, instruction taken this cycle if valid |
| instr_w0 | input | 32 | First word: count in 23:0, indirect bit 29, table bit 28 |
| instr_w1 | input | 32 | Second word: address, pointer or table offset |
| tbl_base | input | 32 | Table base address, sampled at acceptance |
| rd_req | output | 1 | Pointer or table read request |
| rd_addr | output | 32 | Read address, held until acknowledged |
| rd_ack | input | 1 | Read acknowledge, data valid this cycle |
| rd_data | input | 32 | Read data |
| xfer_valid | output | 1 | Data beat requested |
| xfer_ready | input | 1 | Beat performed this cycle |
| xfer_addr | output | 32 | Address of the beat |
| xfer_max | output | 3 | Most bytes the beat may carry (1 to 4) |
| xfer_bytes | input | 3 | Bytes actually moved, read with `xfer_ready` |
| next_req | output | 1 | One-cycle request to fetch the next instruction |
| illegal_err | output | 1 | One-cycle pulse for a rejected instruction |

## Verification
The properties assume that the transfer side reports `xfer_bytes` between 1 and the offered `xfer_max` in every cycle where it raises `xfer_ready`. They also assume that `rd_ack` is raised only while `rd_req` is high. The bench derives each byte report by folding a cycle counter into the range 1 to `xfer_max`. It raises acknowledges only against a visible request, and it stalls both ports on a fixed cycle pattern so that the holding rules are exercised. Each sweep covers every mode, counts around and above the beat limit, two stall phases, and an address that wraps past the top of the 32-bit space.

// File: rtl/bmv_pkg.sv
package bmv_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'd0,
    MODE_INDIRECT = 2'd1,
    MODE_TABLE    = 2'd2,
    MODE_BAD      = 2'd3
  } bmv_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PTR   = 3'd1,
    ST_TCNT  = 3'd2,
    ST_TADDR = 3'd3,
    ST_XFER  = 3'd4,
    ST_DONE  = 3'd5,
    ST_ERR   = 3'd6
  } bmv_state_e;

endpackage

// File: rtl/bmv_mode_dec.sv
module bmv_mode_dec
  import bmv_pkg::*;
(
  input  logic      ind_bit,
  input  logic      tbl_bit,
  output bmv_mode_e mode
);

  always_comb begin
    unique case ({ind_bit, tbl_bit})
      2'b00:   mode = MODE_DIRECT;
      2'b10:   mode = MODE_INDIRECT;
      2'b01:   mode = MODE_TABLE;
      default: mode = MODE_BAD;
    endcase
  end

endmodule

// File: rtl/bmv_counter.sv
module bmv_counter #(
  parameter int AW       = 32,
  parameter int CW       = 24,
  parameter int BEAT_MAX = 4,
  localparam int BW      = $clog2(BEAT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_cnt,
  input  logic [CW-1:0] cnt_in,
  input  logic          load_addr,
  input  logic [AW-1:0] addr_in,
  input  logic          step,
  input  logic [BW-1:0] step_bytes,
  output logic [CW-1:0] rem_o,
  output logic [AW-1:0] addr_o,
  output logic [BW-1:0] beat_max_o
);

  logic [CW-1:0] rem_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (load_cnt) begin
      rem_q <= cnt_in;
    end else if (step) begin
      rem_q <= rem_q - CW'(step_bytes);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load_addr) begin
      addr_q <= addr_in;
    end else if (step) begin
      addr_q <= addr_q + AW'(step_bytes);
    end
  end

  // largest beat allowed: never more than what remains
  always_comb begin
    if (rem_q >= CW'(BEAT_MAX)) begin
      beat_max_o = BW'(BEAT_MAX);
    end else begin
      beat_max_o = rem_q[BW-1:0];
    end
  end

  assign rem_o  = rem_q;
  assign addr_o = addr_q;

endmodule

// File: rtl/bmv_ctrl.sv
module bmv_ctrl
  import bmv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       instr_fire,
  input  bmv_mode_e  mode,
  input  logic       w0_cnt_zero,
  input  logic       rd_ack,
  input  logic       tbl_cnt_zero,
  input  logic       beat_fire,
  input  logic       beat_last,
  output bmv_state_e state_o
);

  bmv_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (instr_fire) begin
          unique case (mode)
            MODE_DIRECT:   state_d = w0_cnt_zero ? ST_DONE : ST_XFER;
            MODE_INDIRECT: state_d = w0_cnt_zero ? ST_DONE : ST_PTR;
            MODE_TABLE:    state_d = ST_TCNT;
            default:       state_d = ST_ERR;
          endcase
        end
      end
      ST_PTR:   if (rd_ack) state_d = ST_XFER;
      ST_TCNT:  if (rd_ack) state_d = tbl_cnt_zero ? ST_DONE : ST_TADDR;
      ST_TADDR: if (rd_ack) state_d = ST_XFER;
      ST_XFER:  if (beat_fire && beat_last) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      ST_ERR:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/blkmove_seq.sv
module blkmove_seq #(
  parameter int AW       = 32,
  parameter int IW       = 32,
  parameter int CW       = 24,
  parameter int BEAT_MAX = 4,
  parameter int IND_BIT  = 29,
  parameter int TBL_BIT  = 28,
  localparam int BW      = $clog2(BEAT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  output logic          instr_ready,
  input  logic [IW-1:0] instr_w0,
  input  logic [AW-1:0] instr_w1,
  input  logic [AW-1:0] tbl_base,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [AW-1:0] rd_data,
  output logic          xfer_valid,
  input  logic          xfer_ready,
  output logic [AW-1:0] xfer_addr,
  output logic [BW-1:0] xfer_max,
  input  logic [BW-1:0] xfer_bytes,
  output logic          next_req,
  output logic          illegal_err
);
  import bmv_pkg::*;

  localparam logic [AW-1:0] ENT_STRIDE = AW'(AW / 8);

  bmv_mode_e     mode;
  bmv_state_e    state;
  logic          instr_fire;
  logic          beat_fire;
  logic          beat_last;
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ent_q;
  logic          load_cnt;
  logic [CW-1:0] cnt_in;
  logic          load_addr;
  logic [AW-1:0] addr_in;
  logic [CW-1:0] rem_w;
  logic [AW-1:0] addr_w;
  logic [BW-1:0] beat_max_w;
  logic          w0_unused_bits;

  assign w0_unused_bits = ^instr_w0[IW-1:CW];

  bmv_mode_dec u_dec (
    .ind_bit (instr_w0[IND_BIT]),
    .tbl_bit (instr_w0[TBL_BIT]),
    .mode    (mode)
  );

  assign instr_ready = (state == ST_IDLE);
  assign instr_fire  = instr_valid && instr_ready;

  // operand latches: pointer and table entry address taken at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      ent_q <= '0;
    end else if (instr_fire) begin
      ptr_q <= instr_w1;
      ent_q <= tbl_base + instr_w1;
    end
  end

  // memory read port
  assign rd_req = (state == ST_PTR) || (state == ST_TCNT) || (state == ST_TADDR);
  always_comb begin
    unique case (state)
      ST_PTR:   rd_addr = ptr_q;
      ST_TCNT:  rd_addr = ent_q;
      ST_TADDR: rd_addr = ent_q + ENT_STRIDE;
      default:  rd_addr = '0;
    endcase
  end

  // register load selection
  always_comb begin
    load_cnt  = 1'b0;
    cnt_in    = instr_w0[CW-1:0];
    load_addr = 1'b0;
    addr_in   = rd_data;
    if (instr_fire) begin
      load_cnt  = (mode == MODE_DIRECT) || (mode == MODE_INDIRECT);
      load_addr = (mode == MODE_DIRECT);
      addr_in   = instr_w1;
    end else if (rd_req && rd_ack) begin
      if (state == ST_TCNT) begin
        load_cnt = 1'b1;
        cnt_in   = rd_data[CW-1:0];
      end else begin
        load_addr = 1'b1;
      end
    end
  end

  assign xfer_valid = (state == ST_XFER);
  assign beat_fire  = xfer_valid && xfer_ready;
  assign beat_last  = (rem_w == CW'(xfer_bytes));

  bmv_counter #(
    .AW       (AW),
    .CW       (CW),
    .BEAT_MAX (BEAT_MAX)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_cnt   (load_cnt),
    .cnt_in     (cnt_in),
    .load_addr  (load_addr),
    .addr_in    (addr_in),
    .step       (beat_fire),
    .step_bytes (xfer_bytes),
    .rem_o      (rem_w),
    .addr_o     (addr_w),
    .beat_max_o (beat_max_w)
  );

  bmv_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_fire   (instr_fire),
    .mode         (mode),
    .w0_cnt_zero  (instr_w0[CW-1:0] == '0),
    .rd_ack       (rd_ack),
    .tbl_cnt_zero (rd_data[CW-1:0] == '0),
    .beat_fire    (beat_fire),
    .beat_last    (beat_last),
    .state_o      (state)
  );

  assign xfer_addr   = addr_w;
  assign xfer_max    = beat_max_w;
  assign next_req    = (state == ST_DONE);
  assign illegal_err = (state == ST_ERR);

endmodule

// File: rtl/bmv_chk.sv
module bmv_chk #(
  parameter int AW       = 32,
  parameter int CW       = 24,
  parameter int BEAT_MAX = 4,
  localparam int BW      = $clog2(BEAT_MAX + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          instr_valid,
  input logic          instr_ready,
  input logic          ind_bit,
  input logic          tbl_bit,
  input logic          rd_req,
  input logic          rd_ack,
  input logic [AW-1:0] rd_addr,
  input logic          xfer_valid,
  input logic          xfer_ready,
  input logic [AW-1:0] xfer_addr,
  input logic [BW-1:0] xfer_max,
  input logic [BW-1:0] xfer_bytes,
  input logic          next_req,
  input logic          illegal_err,
  input logic [CW-1:0] rem
);

  // R1
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && instr_ready |=> !instr_ready);

  // R4
  beat_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (xfer_max != '0) && (xfer_max <= BW'(BEAT_MAX)) && (CW'(xfer_max) <= rem));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && xfer_ready |=>
      (!xfer_valid || xfer_addr == $past(xfer_addr) + AW'($past(xfer_bytes))));

  // R3
  rem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && xfer_ready |=> rem == $past(rem) - CW'($past(xfer_bytes)));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    next_req |=> !next_req && instr_ready);

  // R8
  bad_instr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && instr_ready && ind_bit && tbl_bit |=> illegal_err && !rd_req && !xfer_valid && !next_req);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

  // R11
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr) && $stable(xfer_max));

endmodule

bind blkmove_seq bmv_chk #(
  .AW       (AW),
  .CW       (CW),
  .BEAT_MAX (BEAT_MAX)
) u_bmv_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .instr_ready (instr_ready),
  .ind_bit     (instr_w0[IND_BIT]),
  .tbl_bit     (instr_w0[TBL_BIT]),
  .rd_req      (rd_req),
  .rd_ack      (rd_ack),
  .rd_addr     (rd_addr),
  .xfer_valid  (xfer_valid),
  .xfer_ready  (xfer_ready),
  .xfer_addr   (xfer_addr),
  .xfer_max    (xfer_max),
  .xfer_bytes  (xfer_bytes),
  .next_req    (next_req),
  .illegal_err (illegal_err),
  .rem         (rem_w)
);

// File: tb/test_blkmove_seq.sv
module test_blkmove_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [31:0] instr_w0 = '0;
  logic [31:0] instr_w1 = '0;
  logic [31:0] tbl_base = '0;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_ack = 1'b0;
  logic [31:0] rd_data = '0;
  logic        xfer_valid;
  logic        xfer_ready = 1'b0;
  logic [31:0] xfer_addr;
  logic [2:0]  xfer_max;
  logic [2:0]  xfer_bytes = 3'd1;
  logic        next_req;
  logic        illegal_err;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  blkmove_seq i_blkmove_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_ready (instr_ready),
    .instr_w0    (instr_w0),
    .instr_w1    (instr_w1),
    .tbl_base    (tbl_base),
    .rd_req      (rd_req),
    .rd_addr     (rd_addr),
    .rd_ack      (rd_ack),
    .rd_data     (rd_data),
    .xfer_valid  (xfer_valid),
    .xfer_ready  (xfer_ready),
    .xfer_addr   (xfer_addr),
    .xfer_max    (xfer_max),
    .xfer_bytes  (xfer_bytes),
    .next_req    (next_req),
    .illegal_err (illegal_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // one instruction from offer to completion; d0/d1 answer the first/second read
  task automatic run_one(input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] base,
                         input logic [31:0] d0, input logic [31:0] d1, input int seed);
    logic [1:0]  m = w0[29:28];
    int          exp_cnt = 0;
    int          exp_rem;
    int          exp_nrd = 0;
    logic [31:0] exp_addr = '0;
    logic [31:0] rexp0 = '0;
    logic [31:0] rexp1 = '0;
    int          nrd = 0;
    int          moved = 0;
    int          cyc = 0;
    int          lim;
    int          b;
    bit          saw_done = 0;
    bit          saw_err = 0;
    string       rtag;

    unique case (m)
      2'b00: begin exp_cnt = int'(w0[23:0]); exp_addr = w1; exp_nrd = 0; rtag = "R2"; end
      2'b10: begin exp_cnt = int'(w0[23:0]); exp_addr = d0; rexp0 = w1;
                   exp_nrd = (exp_cnt == 0) ? 0 : 1; rtag = "R6"; end
      2'b01: begin exp_cnt = int'(d0[23:0]); exp_addr = d1; rexp0 = base + w1; rexp1 = base + w1 + 32'd4;
                   exp_nrd = (exp_cnt == 0) ? 1 : 2; rtag = "R7"; end
      default: begin exp_cnt = 0; exp_nrd = 0; rtag = "R8"; end
    endcase
    if (exp_cnt == 0 && m != 2'b11) rtag = "R9";
    exp_rem = exp_cnt;

    instr_w0 = w0; instr_w1 = w1; tbl_base = base; instr_valid = 1'b1;
    chk(instr_ready == 1'b1, "R1", 32'(instr_ready), 32'd1);
    @(posedge clk); @(negedge clk);
    instr_valid = 1'b0;
    instr_w1 = 32'hDEAD_0000; tbl_base = 32'h0BAD_0000;
    chk(instr_ready == 1'b0, "R1", 32'(instr_ready), 32'd0);

    while (!saw_done && !saw_err && cyc < 400) begin
      rd_ack = 1'b0; xfer_ready = 1'b0;
      if (rd_req) begin
        chk(nrd < exp_nrd, rtag, 32'(nrd), 32'(exp_nrd));
        chk(rd_addr == ((nrd == 0) ? rexp0 : rexp1), (nrd == 0) ? rtag : "R10", rd_addr, (nrd == 0) ? rexp0 : rexp1);
        if ((cyc + seed) % 2 == 0) begin
          rd_ack = 1'b1;
          rd_data = (nrd == 0) ? d0 : d1;
          nrd++;
        end
      end
      if (xfer_valid) begin
        lim = (exp_rem < 4) ? exp_rem : 4;
        chk(xfer_addr == exp_addr, "R3", xfer_addr, exp_addr);
        chk(int'(xfer_max) == lim, "R4", 32'(xfer_max), 32'(lim));
        if ((cyc + seed) % 3 != 0) begin
          b = 1 + ((cyc * 3 + seed) % ((xfer_max == 0) ? 1 : int'(xfer_max)));
          xfer_bytes = 3'(b);
          xfer_ready = 1'b1;
          exp_rem -= b;
          exp_addr += 32'(b);
          moved += b;
        end
      end
      if (next_req) saw_done = 1;
      if (illegal_err) saw_err = 1;
      @(posedge clk); @(negedge clk);
      cyc++;
    end
    rd_ack = 1'b0; xfer_ready = 1'b0;

    chk(saw_done == (m != 2'b11), "R5", 32'(saw_done), 32'(m != 2'b11));
    chk(saw_err == (m == 2'b11), "R8", 32'(saw_err), 32'(m == 2'b11));
    chk(nrd == exp_nrd, rtag, 32'(nrd), 32'(exp_nrd));
    chk(moved == exp_cnt, (exp_cnt == 0) ? "R9" : "R3", 32'(moved), 32'(exp_cnt));
    chk(instr_ready && !next_req && !illegal_err, "R5", {29'd0, instr_ready, next_req, illegal_err}, 32'd4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    finish_run();
  end

  initial begin
    int cnts[8] = '{0, 1, 2, 3, 4, 5, 7, 9};
    logic [31:0] w0, w1, base, d0, d1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(instr_ready == 1'b1 && !rd_req && !xfer_valid && !next_req && !illegal_err, "R1",
        {27'd0, instr_ready, rd_req, xfer_valid, next_req, illegal_err}, 32'h10);
    rst_n = 1'b1;
    @(negedge clk);
    chk(instr_ready == 1'b1, "R1", 32'(instr_ready), 32'd1);

    for (int mi = 0; mi < 4; mi++) begin
      for (int ci = 0; ci < 8; ci++) begin
        for (int seed = 0; seed < 2; seed++) begin
          w1   = 32'h0000_0100 + 32'(ci * 8);
          base = 32'h8000_0000 + 32'(seed * 64);
          w0   = {2'b11, 2'(mi), 4'hA, 24'(cnts[ci])};
          d0   = 32'h1000_0000 + 32'(ci * 16 + seed);
          d1   = 32'h2000_0FFE + 32'(ci);
          if (mi == 1) begin
            // table: w0 count ignored, entry count with junk in upper byte
            w0 = {2'b11, 2'b01, 4'hA, 24'h00BEEF ^ 24'(ci)};
            d0 = {8'h5A, 24'(cnts[ci])};
          end
          run_one(w0, w1, base, d0, d1, seed);
        end
      end
    end
    // R3 address wrap past the top of the space
    run_one({2'b00, 2'b00, 4'h0, 24'd9}, 32'hFFFF_FFFE, 32'h0, 32'h0, 32'h0, 1);
    run_one({2'b00, 2'b10, 4'h0, 24'd6}, 32'h0000_0040, 32'h0, 32'hFFFF_FFFD, 32'h0, 0);
    finish_run();
  end

endmodule